// File: doc/BRIEF.md
# Pipelined All-One-Polynomial Field Multiplier

This block multiplies two elements of GF(2^m), where the field is built from the irreducible polynomial whose m+1 coefficients are all one: P(x) = x^m + x^(m-1) + ... + x + 1. Both m-bit operands arrive in parallel on one clock together with a valid flag. The m-bit product leaves in parallel a fixed number of cycles later. Because every stage is a register stage, a fresh operand pair may be presented on every clock.

Internally each operand is widened to m+1 coefficients by adding a zero top coefficient. In that wider ring x^(m+1) = 1, so multiplying by x is a one-place cyclic rotation and no reduction is needed while the product builds up. The array has m/2 rows of m+1 identical AND/XOR cells. Each row takes two bits of the multiplier operand and adds the matching rotations of the multiplicand into a running sum, which makes m(m+1)/2 cells in all. A final XOR network folds the m+1 coefficients back to m bits. The flag rides alongside the data. Reset is asserted asynchronously and released through a two-flop synchronizer. The degree parameter must be even, and m+1 must be a prime for which 2 is a primitive root, for example 4 or 10.

Top module: `aop_mult`

## Requirements
- R1: While rst_n is low, and straight after rst_n falls in the middle of a cycle without waiting for a clock edge, out_valid is 0 and p_out is all zeros. The contents of the pipeline are discarded.
- R2: An operand pair sampled with in_valid=1 at a rising edge produces out_valid=1 after the rising edge M/2 cycles later. The latency is M/2+1 register stages, 3 for M=4. An edge that samples in_valid=0 produces out_valid=0 at the same offset.
- R3: When out_valid is 1, p_out equals a_in times b_in reduced modulo P(x). Bit i of every operand and of the product is the coefficient of x^i.
- R4: Operand pairs presented on consecutive clocks each give their own product on consecutive clocks, in the order they were presented.
- R5: The values on a_in and b_in on an edge where in_valid is 0 do not affect any output.
- R6: Whenever out_valid is 0, p_out is all zeros.
- R7: After rst_n rises, the first two rising edges do not accept inputs. The third rising edge is the first one that accepts an operand pair.
- R8: Field identities hold. Multiplying by 0 gives 0. Multiplying by 1 (value 0...01) returns the other operand. For M=4, x^4 = 4'hF and x^5 = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| in_valid | input | 1 | The operand pair on a_in and b_in is to be multiplied |
| a_in | input | M | Multiplicand, polynomial basis, bit i is the coefficient of x^i |
| b_in | input | M | Multiplier, polynomial basis |
| out_valid | output | 1 | p_out carries a product |
| p_out | output | M | Product modulo P(x), zero when out_valid is 0 |

## Verification
An operand pair driven before rising edge k has its result on the outputs after edge k+M/2, which is M/2+1 registers later. The bench drives and samples only on falling edges. At each falling edge it compares the outputs with the entry it recorded M/2+1 falling edges earlier, and only then drives the next pair. The two cases that are not data are timed separately. The asynchronous reset is checked one nanosecond after rst_n falls in the middle of a cycle. The release is checked by offering operands on the second and third edges after rst_n rises and expecting only the third pair to appear, M/2+1 cycles later.

// File: rtl/aop_pkg.sv
`timescale 1ns/1ps
package aop_pkg;

  // Number of register stages from operand capture to product output.
  function automatic int aop_latency(input int m);
    return m / 2 + 1;
  endfunction

  // The all-one polynomial of degree m is irreducible when m+1 is prime
  // and 2 has multiplicative order m modulo m+1. The array also needs m even.
  function automatic bit aop_degree_ok(input int m);
    int p;
    int r;
    bit ok;
    p  = m + 1;
    ok = (m >= 4) && ((m % 2) == 0);
    for (int d = 2; d < p; d++) begin
      if ((p % d) == 0) ok = 1'b0;
    end
    r = 1;
    for (int k = 1; k <= m; k++) begin
      r = (2 * r) % p;
      if ((r == 1) && (k < m)) ok = 1'b0;
    end
    if (r != 1) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/aop_rst_sync.sv
`timescale 1ns/1ps
module aop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/aop_lift.sv
`timescale 1ns/1ps
// Stage 0: capture operands and lift the multiplicand to m+1 coefficients.
module aop_lift #(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic         v_out,
  output logic [M:0]   a_ext,
  output logic [M-1:0] b_out
);
  logic         v_q;
  logic [M-1:0] a_q;
  logic [M-1:0] b_q;
  logic         v_d;
  logic         load;

  always_comb begin
    v_d  = in_valid;
    load = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  assign v_out = v_q;
  assign a_ext = {1'b0, a_q};
  assign b_out = b_q;
endmodule

// File: rtl/aop_stage.sv
`timescale 1ns/1ps
// One row of m+1 identical cells: takes the two lowest remaining multiplier
// bits, adds the multiplicand and its one-place rotation into the sum, and
// hands on the multiplicand rotated by two places.
module aop_stage #(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  input  logic [M:0]   a_in,
  input  logic [M-1:0] b_in,
  input  logic [M:0]   acc_in,
  output logic         v_out,
  output logic [M:0]   a_out,
  output logic [M-1:0] b_out,
  output logic [M:0]   acc_out
);
  localparam int W = M + 1;

  logic [M:0]   acc_d;
  logic [M:0]   a_d;
  logic [M-1:0] b_d;
  logic         v_q;
  logic [M:0]   acc_q;
  logic [M:0]   a_q;
  logic [M-1:0] b_q;

  for (genvar j = 0; j < W; j++) begin : g_cell
    always_comb begin
      acc_d[j] = acc_in[j]
               ^ (b_in[0] & a_in[j])
               ^ (b_in[1] & a_in[(j + M) % W]);
      a_d[j]   = a_in[(j + M - 1) % W];
    end
  end

  always_comb begin
    b_d = {2'b00, b_in[M-1:2]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    if (v_in) begin
      acc_q <= acc_d;
      a_q   <= a_d;
      b_q   <= b_d;
    end
  end

  assign v_out   = v_q;
  assign a_out   = a_q;
  assign b_out   = b_q;
  assign acc_out = acc_q;
endmodule

// File: rtl/aop_reduce.sv
`timescale 1ns/1ps
// Fold the m+1 redundant coefficients back to m bits: x^m equals the sum
// of all lower powers, so the top coefficient is added into every bit.
module aop_reduce #(
  parameter int M = 4
) (
  input  logic         v_in,
  input  logic [M:0]   c_in,
  output logic [M-1:0] p_out
);
  always_comb begin
    if (v_in) p_out = c_in[M-1:0] ^ {M{c_in[M]}};
    else      p_out = '0;
  end
endmodule

// File: rtl/aop_mult.sv
`timescale 1ns/1ps
module aop_mult #(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic         out_valid,
  output logic [M-1:0] p_out
);
  localparam int NS  = M / 2;
  localparam int LAT = aop_pkg::aop_latency(M);

  if (!aop_pkg::aop_degree_ok(M)) begin : g_bad_degree
    $error("aop_mult: M must be even with M+1 prime and 2 primitive mod M+1");
  end

  logic         rst_sync_n;
  logic         v_s   [0:NS];
  logic [M:0]   a_s   [0:NS];
  logic [M-1:0] b_s   [0:NS];
  logic [M:0]   acc_s [0:NS];

  aop_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  aop_lift #(.M(M)) u_lift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .a_in     (a_in),
    .b_in     (b_in),
    .v_out    (v_s[0]),
    .a_ext    (a_s[0]),
    .b_out    (b_s[0])
  );

  assign acc_s[0] = '0;

  for (genvar k = 0; k < NS; k++) begin : g_row
    aop_stage #(.M(M)) u_stage (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .v_in    (v_s[k]),
      .a_in    (a_s[k]),
      .b_in    (b_s[k]),
      .acc_in  (acc_s[k]),
      .v_out   (v_s[k+1]),
      .a_out   (a_s[k+1]),
      .b_out   (b_s[k+1]),
      .acc_out (acc_s[k+1])
    );
  end

  aop_reduce #(.M(M)) u_reduce (
    .v_in  (v_s[NS]),
    .c_in  (acc_s[NS]),
    .p_out (p_out)
  );

  assign out_valid = v_s[NS];

  if (LAT != NS + 1) begin : g_bad_lat
    $error("aop_mult: latency bookkeeping mismatch");
  end
endmodule

// File: rtl/aop_mult_chk.sv
`timescale 1ns/1ps
module aop_mult_chk #(
  parameter int M = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [M-1:0] a_in,
  input logic [M-1:0] b_in,
  input logic         out_valid,
  input logic [M-1:0] p_out
);
  localparam int LAT = aop_pkg::aop_latency(M);

  logic         vsh [0:LAT-1];
  logic [M-1:0] ash [0:LAT-1];
  logic [M-1:0] bsh [0:LAT-1];
  logic         rst_seen;

  function automatic logic [M-1:0] serial_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = {r[M-2:0], 1'b0} ^ {M{r[M-1]}};
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) vsh[i] <= 1'b0;
    end else begin
      vsh[0] <= in_valid;
      for (int i = 1; i < LAT; i++) vsh[i] <= vsh[i-1];
    end
  end

  always_ff @(posedge clk) begin
    ash[0] <= a_in;
    bsh[0] <= b_in;
    for (int i = 1; i < LAT; i++) begin
      ash[i] <= ash[i-1];
      bsh[i] <= bsh[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_seen <= 1'b0;
    else        rst_seen <= 1'b1;
  end

  // R1 / R7: the first cycle after the internal reset lifts carries no result
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_seen |-> !out_valid);

  // R2
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vsh[LAT-1]);

  // R3
  a_r3_product: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (p_out == serial_mul(ash[LAT-1], bsh[LAT-1])));

  // R6
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (p_out == '0));
endmodule

bind aop_mult aop_mult_chk #(.M(M)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .a_in      (a_in),
  .b_in      (b_in),
  .out_valid (out_valid),
  .p_out     (p_out)
);

// File: tb/aop_mult_tb.sv
`timescale 1ns/1ps
module aop_mult_tb;
  localparam int M   = 4;
  localparam int LAT = M / 2 + 1;

  // {a, b, expected product} for M=4, worked out by hand modulo x^4+x^3+x^2+x+1
  localparam logic [11:0] VECS [0:11] = '{
    12'h199, 12'h050, 12'h28F, 12'h481, 12'h882, 12'hFF8,
    12'hF21, 12'h335, 12'h651, 12'h791, 12'hAC4, 12'h5B6
  };

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [M-1:0] a_in;
  logic [M-1:0] b_in;
  logic         out_valid;
  logic [M-1:0] p_out;

  int checks;
  int fails;
  int idx;
  logic [15:0]  lf;
  logic         exp_v   [0:255];
  logic [M-1:0] exp_p   [0:255];
  string        exp_tag [0:255];

  aop_mult #(.M(M)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_in      (a_in),
    .b_in      (b_in),
    .out_valid (out_valid),
    .p_out     (p_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = {r[M-2:0], 1'b0} ^ {M{r[M-1]}};
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic compare(input logic av, input logic [M-1:0] ap,
                         input logic ev, input logic [M-1:0] ep, input string tag);
    checks++;
    if (av !== ev || ap !== ep) begin
      fails++;
      $display("FAIL %s: out_valid=%0b p_out=%h, expected out_valid=%0b p_out=%h",
               (av !== ev) ? {"R2/", tag} : tag, av, ap, ev, ep);
    end
  endtask

  // At a falling edge: check the slot driven LAT falling edges ago, then drive.
  task automatic step(input logic v, input logic [M-1:0] a, input logic [M-1:0] b,
                      input logic accept, input logic [M-1:0] ep, input string tag);
    int s;
    @(negedge clk);
    if (idx >= LAT) begin
      s = (idx - LAT) % 256;
      compare(out_valid, p_out, exp_v[s], exp_v[s] ? exp_p[s] : '0, exp_tag[s]);
    end else begin
      compare(out_valid, p_out, 1'b0, '0, "R1");
    end
    in_valid = v;
    a_in     = a;
    b_in     = b;
    exp_v[idx % 256]   = v & accept;
    exp_p[idx % 256]   = ep;
    exp_tag[idx % 256] = tag;
    idx++;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n    = 1'b1;
    in_valid = 1'b0;
    exp_v[0]   = 1'b0;
    exp_p[0]   = '0;
    exp_tag[0] = "R7";
    idx = 1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [M-1:0] ra;
    logic [M-1:0] rb;
    checks = 0;
    fails  = 0;
    idx    = 0;
    lf     = 16'hACE1;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    a_in     = '0;
    b_in     = '0;

    // R1: quiet during reset
    repeat (3) @(negedge clk);
    compare(out_valid, p_out, 1'b0, '0, "R1");

    // R7: second edge after release is ignored, table follows from the third
    release_reset();
    step(1'b1, 4'h5, 4'h5, 1'b0, '0, "R7");

    // R3 / R8: hand-computed vectors back to back
    for (int i = 0; i < 12; i++) begin
      step(1'b1, VECS[i][11:8], VECS[i][7:4], 1'b1, VECS[i][3:0],
           (i < 7) ? "R8" : "R3");
    end

    // R4: continuous random stream
    for (int i = 0; i < 40; i++) begin
      rnd();
      ra = lf[3:0];
      rb = lf[7:4];
      step(1'b1, ra, rb, 1'b1, ref_mul(ra, rb), "R4");
    end

    // R5: gaps carrying garbage operands
    for (int i = 0; i < 30; i++) begin
      rnd();
      ra = lf[3:0];
      rb = lf[11:8];
      if (lf[5]) step(1'b1, ra, rb, 1'b1, ref_mul(ra, rb), "R5");
      else       step(1'b0, ra, rb, 1'b0, '0, "R5");
    end

    // R6: drain, outputs must fall to zero
    for (int i = 0; i < LAT + 2; i++) begin
      rnd();
      step(1'b0, lf[3:0], lf[7:4], 1'b0, '0, "R6");
    end

    // R1: asynchronous reset in the middle of a cycle with results in flight
    for (int i = 0; i < LAT + 1; i++) begin
      rnd();
      ra = lf[3:0] | 4'h1;
      rb = lf[7:4] | 4'h1;
      step(1'b1, ra, rb, 1'b1, ref_mul(ra, rb), "R4");
    end
    #5;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    #1;
    compare(out_valid, p_out, 1'b0, '0, "R1");
    repeat (2) @(negedge clk);
    compare(out_valid, p_out, 1'b0, '0, "R1");

    // R7: edge two ignored, edge three accepted
    release_reset();
    step(1'b1, 4'h7, 4'h9, 1'b0, '0, "R7");
    step(1'b1, 4'hA, 4'hC, 1'b1, 4'h4, "R7");
    for (int i = 0; i < LAT + 1; i++) begin
      step(1'b0, 4'hF, 4'hF, 1'b0, '0, "R6");
    end

    summary();
    $finish;
  end
endmodule